// File: doc/BRIEF.md
# Store-to-Load Forwarding Check Unit

This unit decides, for one load at a time, where the load's data must come from. The load arrives with its byte address, its byte size and the store-queue slot that was current when it was dispatched. The unit compares the load against the older stores still held in the store queue. The contents of the queue are presented on flat input buses; this unit does not store them. The result is exactly one of five outcomes. A store that holds all of the load's bytes supplies the data directly. A store that holds only some of the load's bytes, and has not yet written memory, forces a stall and a replay. An uncacheable load that is issued too early is sent back with a machine-check indication. Otherwise the load proceeds to the cache, or is reported as blocked when the cache cannot accept it.

Two small trackers sit beside the search. The stall tracker keeps the oldest load that is waiting on a partially overlapping store, together with that store's sequence number. It releases when that store reports that its writeback has finished. The blocked tracker keeps the sequence number of the oldest load that found the cache blocked, and software-side logic releases it with a clear pulse.

Requests use a valid/ready handshake. Results leave through a one-deep registered valid/ready stage. A request is taken when `req_valid` and `req_ready` are both high. Its result appears with `res_valid` on the next cycle. `req_ready` is low only while a result is waiting and `res_ready` is low, so a stalled consumer holds back new requests without losing a result.

Top module: `stlf_check`

## Requirements
- R1: The search window is the set of slots from `req_sq_idx`-1 going down to `sq_wb_idx` inclusive, modulo SQ_DEPTH (a power of two). When `req_sq_idx` equals `sq_wb_idx` the window is empty and no store is considered. Slots outside the window never affect the result.
- R2: Among the stores in the window that qualify, the one nearest to `req_sq_idx` (the youngest) decides the result, and its slot is reported on `res_sq_idx`.
- R3: A slot whose size field is zero is passed over as if absent.
- R4: A store fully covers the load when load_addr >= store_addr and load_addr+load_size <= store_addr+store_size. A full cover gives kind bit 0 (forward). The data is then the store data shifted right by 8*(load_addr & (store_size-1)), with bytes at or above load_size forced to zero.
- R5: A partial overlap means the byte ranges intersect without a full cover. If that store's done flag is low, the result is kind bit 1 (stall-replay). If its done flag is high, the store is passed over and the search continues.
- R6: A stall-replay raises `stall_active` and records the store's sequence number and the load's index and sequence number. An existing record is replaced only if no stall is pending or the new load is older, where a smaller sequence number means older.
- R7: The stall record clears when `wb_done` is high with `wb_seq` equal to the recorded store sequence number. In the same cycle the clear is applied first, so a new stall-replay in that cycle installs its own record.
- R8: An uncacheable load whose `req_lq_idx` differs from `lq_head`, or whose `req_at_commit` is low, gives kind bit 2 (uncacheable replay / machine check) and leaves both trackers unchanged. An uncacheable load at the head and at commit is handled like any other load.
- R9: With no qualifying store, the result is kind bit 3 (cache access) when `cache_blocked` is low and kind bit 4 (cache blocked) when it is high. Result data is zero for every kind except forward.
- R10: A cache-blocked result raises `blk_active` with the load's sequence number, unless an older load is already recorded. `blk_clear` drops the record, and is applied before a same-cycle new record.
- R11: After reset `res_valid`, `stall_active` and `blk_active` are low. A taken request produces `res_valid` on the next cycle, and that result holds unchanged while `res_ready` is low. `req_ready` = !`res_valid` || `res_ready`.
- R12: Whenever `res_valid` is high, exactly one bit of `res_kind` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | AW | Load byte address |
| req_size | input | SZW | Load size in bytes (1, 2, 4, 8) |
| req_sq_idx | input | SQW | Store-queue slot recorded for the load |
| req_lq_idx | input | LQW | Load-queue index of the load |
| req_seq | input | SEQ_W | Load sequence number (smaller is older) |
| req_uncached | input | 1 | Load targets uncacheable space |
| req_at_commit | input | 1 | Load has reached commit |
| lq_head | input | LQW | Current load-queue head index |
| sq_wb_idx | input | SQW | Store-queue writeback pointer |
| cache_blocked | input | 1 | Cache cannot accept an access |
| sq_addr | input | SQ_DEPTH*AW | Per-slot store address |
| sq_size | input | SQ_DEPTH*SZW | Per-slot store size in bytes, 0 = no data yet |
| sq_data | input | SQ_DEPTH*DW | Per-slot store data |
| sq_done | input | SQ_DEPTH | Per-slot store already written to memory |
| sq_seq | input | SQ_DEPTH*SEQ_W | Per-slot store sequence number |
| wb_done | input | 1 | A store finished its writeback |
| wb_seq | input | SEQ_W | Sequence number of that store |
| blk_clear | input | 1 | Drop the blocked-load record |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_kind | output | 5 | One-hot outcome: 0 forward, 1 stall, 2 uncacheable, 3 cache, 4 blocked |
| res_data | output | DW | Forwarded data |
| res_lq_idx | output | LQW | Load index of the result |
| res_sq_idx | output | SQW | Deciding store slot (forward or stall) |
| stall_active | output | 1 | A partial-overlap stall is pending |
| stall_store_seq | output | SEQ_W | Recorded store sequence number |
| stall_load_idx | output | LQW | Recorded load index |
| stall_load_seq | output | SEQ_W | Recorded load sequence number |
| blk_active | output | 1 | A blocked load is recorded |
| blk_seq | output | SEQ_W | Recorded blocked load sequence number |

## Verification
The release of the stall record and the installation of a new record can fall in the same cycle. This happens when a partially overlapping load is taken on the edge where `wb_done` names the recorded store. The bench provokes this directly, using a new load younger than the recorded one, and it also occurs many times under random stimulus. The bench judges it by the rule that the clear is applied before the set, so the new load's record must be the one that remains. The blocked tracker meets the same conflict when `blk_clear` coincides with a blocked result, and the bench judges it by the same rule.

// File: rtl/stlf_pkg.sv
package stlf_pkg;
  localparam int KIND_W  = 5;
  localparam int K_FWD   = 0;
  localparam int K_STALL = 1;
  localparam int K_UNC   = 2;
  localparam int K_MEM   = 3;
  localparam int K_BLK   = 4;

  function automatic logic [KIND_W-1:0] kind_bit(input int pos);
    return KIND_W'(1) << pos;
  endfunction
endpackage

// File: rtl/stlf_span_cmp.sv
module stlf_span_cmp #(
  parameter int AW  = 16,
  parameter int SZW = 4
) (
  input  logic [AW-1:0]  ld_addr,
  input  logic [SZW-1:0] ld_size,
  input  logic [AW-1:0]  st_addr,
  input  logic [SZW-1:0] st_size,
  output logic           full,
  output logic           part
);
  localparam int EW = AW + 1;

  logic [EW-1:0] ld_lo, ld_hi, st_lo, st_hi;
  logic          overlap;

  // one extra bit so that the end of a range never wraps
  assign ld_lo = {1'b0, ld_addr};
  assign st_lo = {1'b0, st_addr};
  assign ld_hi = ld_lo + EW'(ld_size);
  assign st_hi = st_lo + EW'(st_size);

  assign full    = (ld_lo >= st_lo) && (ld_hi <= st_hi);
  assign overlap = (ld_lo < st_hi) && (ld_hi > st_lo);
  assign part    = overlap && !full;
endmodule

// File: rtl/stlf_age_scan.sv
module stlf_age_scan #(
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic [IW-1:0]    start_idx,
  input  logic [IW-1:0]    wb_idx,
  input  logic [DEPTH-1:0] live,
  input  logic [DEPTH-1:0] full,
  input  logic [DEPTH-1:0] part,
  input  logic [DEPTH-1:0] done,
  output logic             hit,
  output logic             hit_full,
  output logic [IW-1:0]    hit_idx
);
  logic [IW-1:0]    span;
  logic [IW-1:0]    slot [DEPTH];
  logic [DEPTH-1:0] cand;

  assign span = start_idx - wb_idx;

  // age position k holds the k-th store older than the load
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    assign slot[k] = start_idx - IW'(k + 1);
    assign cand[k] = (IW'(k) < span) && live[slot[k]] &&
                     (full[slot[k]] || (part[slot[k]] && !done[slot[k]]));
  end

  // youngest qualifying position wins: lowest k assigned last
  always_comb begin
    hit      = 1'b0;
    hit_full = 1'b0;
    hit_idx  = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (cand[k]) begin
        hit      = 1'b1;
        hit_full = full[slot[k]];
        hit_idx  = slot[k];
      end
    end
  end
endmodule

// File: rtl/stlf_track.sv
module stlf_track #(
  parameter int SEQ_W = 8,
  parameter int LQW   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_req,
  input  logic [SEQ_W-1:0] stall_ld_seq,
  input  logic [LQW-1:0]   stall_ld_idx,
  input  logic [SEQ_W-1:0] stall_st_seq,
  input  logic             wb_done,
  input  logic [SEQ_W-1:0] wb_seq,
  input  logic             blk_req,
  input  logic [SEQ_W-1:0] blk_ld_seq,
  input  logic             blk_clear,
  output logic             stall_active,
  output logic [SEQ_W-1:0] stall_store_seq,
  output logic [LQW-1:0]   stall_load_idx,
  output logic [SEQ_W-1:0] stall_load_seq,
  output logic             blk_active,
  output logic [SEQ_W-1:0] blk_seq
);
  logic stall_clr, stall_pend, stall_take;
  logic blk_pend, blk_take;

  assign stall_clr  = stall_active && wb_done && (wb_seq == stall_store_seq);
  assign stall_pend = stall_active && !stall_clr;
  assign stall_take = stall_req && (!stall_pend || (stall_ld_seq < stall_load_seq));

  assign blk_pend = blk_active && !blk_clear;
  assign blk_take = blk_req && (!blk_pend || (blk_ld_seq < blk_seq));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_active    <= 1'b0;
      stall_store_seq <= '0;
      stall_load_idx  <= '0;
      stall_load_seq  <= '0;
    end else if (stall_take) begin
      stall_active    <= 1'b1;
      stall_store_seq <= stall_st_seq;
      stall_load_idx  <= stall_ld_idx;
      stall_load_seq  <= stall_ld_seq;
    end else begin
      stall_active    <= stall_pend;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_active <= 1'b0;
      blk_seq    <= '0;
    end else if (blk_take) begin
      blk_active <= 1'b1;
      blk_seq    <= blk_ld_seq;
    end else begin
      blk_active <= blk_pend;
    end
  end

  // R6
  stall_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_active && !stall_clr) |=> (stall_active && (stall_load_seq <= $past(stall_load_seq))));

  // R7
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_active && wb_done && (wb_seq == stall_store_seq) && !stall_req) |=> !stall_active);

  // R10
  blk_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_active && !blk_clear) |=> (blk_active && (blk_seq <= $past(blk_seq))));
endmodule

// File: rtl/stlf_check.sv
module stlf_check
  import stlf_pkg::*;
#(
  parameter int SQ_DEPTH = 8,
  parameter int LQ_DEPTH = 8,
  parameter int AW       = 16,
  parameter int DW       = 64,
  parameter int SEQ_W    = 8,
  parameter int SQW      = $clog2(SQ_DEPTH),
  parameter int LQW      = $clog2(LQ_DEPTH),
  parameter int SZW      = $clog2(DW / 8) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [AW-1:0]             req_addr,
  input  logic [SZW-1:0]            req_size,
  input  logic [SQW-1:0]            req_sq_idx,
  input  logic [LQW-1:0]            req_lq_idx,
  input  logic [SEQ_W-1:0]          req_seq,
  input  logic                      req_uncached,
  input  logic                      req_at_commit,
  input  logic [LQW-1:0]            lq_head,
  input  logic [SQW-1:0]            sq_wb_idx,
  input  logic                      cache_blocked,
  input  logic [SQ_DEPTH*AW-1:0]    sq_addr,
  input  logic [SQ_DEPTH*SZW-1:0]   sq_size,
  input  logic [SQ_DEPTH*DW-1:0]    sq_data,
  input  logic [SQ_DEPTH-1:0]       sq_done,
  input  logic [SQ_DEPTH*SEQ_W-1:0] sq_seq,
  input  logic                      wb_done,
  input  logic [SEQ_W-1:0]          wb_seq,
  input  logic                      blk_clear,
  output logic                      res_valid,
  input  logic                      res_ready,
  output logic [KIND_W-1:0]         res_kind,
  output logic [DW-1:0]             res_data,
  output logic [LQW-1:0]            res_lq_idx,
  output logic [SQW-1:0]            res_sq_idx,
  output logic                      stall_active,
  output logic [SEQ_W-1:0]          stall_store_seq,
  output logic [LQW-1:0]            stall_load_idx,
  output logic [SEQ_W-1:0]          stall_load_seq,
  output logic                      blk_active,
  output logic [SEQ_W-1:0]          blk_seq
);
  localparam int DB = DW / 8;
  localparam int OW = $clog2(DB);

  logic [AW-1:0]    st_addr [SQ_DEPTH];
  logic [SZW-1:0]   st_size [SQ_DEPTH];
  logic [DW-1:0]    st_data [SQ_DEPTH];
  logic [SEQ_W-1:0] st_seq  [SQ_DEPTH];
  logic [SQ_DEPTH-1:0] ent_live, ent_full, ent_part;

  for (genvar i = 0; i < SQ_DEPTH; i++) begin : g_ent
    assign st_addr[i]  = sq_addr[i*AW +: AW];
    assign st_size[i]  = sq_size[i*SZW +: SZW];
    assign st_data[i]  = sq_data[i*DW +: DW];
    assign st_seq[i]   = sq_seq[i*SEQ_W +: SEQ_W];
    assign ent_live[i] = (st_size[i] != '0);

    stlf_span_cmp #(.AW(AW), .SZW(SZW)) u_cmp (
      .ld_addr (req_addr),
      .ld_size (req_size),
      .st_addr (st_addr[i]),
      .st_size (st_size[i]),
      .full    (ent_full[i]),
      .part    (ent_part[i])
    );
  end

  logic           hit, hit_full;
  logic [SQW-1:0] hit_idx;

  stlf_age_scan #(.DEPTH(SQ_DEPTH), .IW(SQW)) u_scan (
    .start_idx (req_sq_idx),
    .wb_idx    (sq_wb_idx),
    .live      (ent_live),
    .full      (ent_full),
    .part      (ent_part),
    .done      (sq_done),
    .hit       (hit),
    .hit_full  (hit_full),
    .hit_idx   (hit_idx)
  );

  // request acceptance and the uncacheable gate
  logic acc, unc_hold;
  assign req_ready = !res_valid || res_ready;
  assign acc       = req_valid && req_ready;
  assign unc_hold  = req_uncached && !((req_lq_idx == lq_head) && req_at_commit);

  // forwarded data: align to the load offset inside the store, trim to load size
  logic [SZW-1:0] hit_size;
  logic [OW-1:0]  byte_off;
  logic [DW-1:0]  shifted, fwd_data;

  assign hit_size = st_size[hit_idx];
  assign byte_off = req_addr[OW-1:0] & (hit_size[OW-1:0] - OW'(1));
  assign shifted  = st_data[hit_idx] >> {byte_off, 3'b000};

  always_comb begin
    for (int b = 0; b < DB; b++) begin
      fwd_data[b*8 +: 8] = (b < int'(req_size)) ? shifted[b*8 +: 8] : 8'h00;
    end
  end

  logic [KIND_W-1:0] kind_nx;
  always_comb begin
    if (unc_hold)                kind_nx = kind_bit(K_UNC);
    else if (hit && hit_full)    kind_nx = kind_bit(K_FWD);
    else if (hit)                kind_nx = kind_bit(K_STALL);
    else if (cache_blocked)      kind_nx = kind_bit(K_BLK);
    else                         kind_nx = kind_bit(K_MEM);
  end

  // output stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_kind   <= '0;
      res_data   <= '0;
      res_lq_idx <= '0;
      res_sq_idx <= '0;
    end else if (acc) begin
      res_valid  <= 1'b1;
      res_kind   <= kind_nx;
      res_data   <= (!unc_hold && hit && hit_full) ? fwd_data : '0;
      res_lq_idx <= req_lq_idx;
      res_sq_idx <= (!unc_hold && hit) ? hit_idx : '0;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end

  logic stall_req, blk_req;
  assign stall_req = acc && !unc_hold && hit && !hit_full;
  assign blk_req   = acc && !unc_hold && !hit && cache_blocked;

  stlf_track #(.SEQ_W(SEQ_W), .LQW(LQW)) u_track (
    .clk             (clk),
    .rst_n           (rst_n),
    .stall_req       (stall_req),
    .stall_ld_seq    (req_seq),
    .stall_ld_idx    (req_lq_idx),
    .stall_st_seq    (st_seq[hit_idx]),
    .wb_done         (wb_done),
    .wb_seq          (wb_seq),
    .blk_req         (blk_req),
    .blk_ld_seq      (req_seq),
    .blk_clear       (blk_clear),
    .stall_active    (stall_active),
    .stall_store_seq (stall_store_seq),
    .stall_load_idx  (stall_load_idx),
    .stall_load_seq  (stall_load_seq),
    .blk_active      (blk_active),
    .blk_seq         (blk_seq)
  );

  // R12
  kind_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones(res_kind) == 1));

  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_kind) && $stable(res_data) && $stable(res_lq_idx)));

  // R8
  unc_blk_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && unc_hold && !blk_clear) |=> (blk_active == $past(blk_active)));

  // R8
  unc_stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && unc_hold && !wb_done) |=> (stall_active == $past(stall_active)));
endmodule

// File: tb/sim_stlf_check.sv
module sim_stlf_check;
  localparam int D = 8, AW = 16, DW = 64, SW = 8, SQW = 3, LQW = 3, SZW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid, req_uncached, req_at_commit, cache_blocked, wb_done, blk_clear, res_ready;
  logic [AW-1:0]  req_addr;
  logic [SZW-1:0] req_size;
  logic [SQW-1:0] req_sq_idx, sq_wb_idx;
  logic [LQW-1:0] req_lq_idx, lq_head;
  logic [SW-1:0]  req_seq, wb_seq;

  int            s_addr [D];
  int            s_size [D];
  int            s_done [D];
  logic [DW-1:0] s_data [D];
  logic [SW-1:0] s_seq  [D];

  logic [D*AW-1:0]  sq_addr;
  logic [D*SZW-1:0] sq_size;
  logic [D*DW-1:0]  sq_data;
  logic [D-1:0]     sq_done;
  logic [D*SW-1:0]  sq_seq;

  always_comb begin
    for (int i = 0; i < D; i++) begin
      sq_addr[i*AW +: AW]   = AW'(s_addr[i]);
      sq_size[i*SZW +: SZW] = SZW'(s_size[i]);
      sq_data[i*DW +: DW]   = s_data[i];
      sq_done[i]            = (s_done[i] != 0);
      sq_seq[i*SW +: SW]    = s_seq[i];
    end
  end

  logic           req_ready, res_valid, stall_active, blk_active;
  logic [4:0]     res_kind;
  logic [DW-1:0]  res_data;
  logic [LQW-1:0] res_lq_idx, stall_load_idx;
  logic [SQW-1:0] res_sq_idx;
  logic [SW-1:0]  stall_store_seq, stall_load_seq, blk_seq;

  stlf_check u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_size(req_size),
    .req_sq_idx(req_sq_idx), .req_lq_idx(req_lq_idx), .req_seq(req_seq),
    .req_uncached(req_uncached), .req_at_commit(req_at_commit), .lq_head(lq_head),
    .sq_wb_idx(sq_wb_idx), .cache_blocked(cache_blocked),
    .sq_addr(sq_addr), .sq_size(sq_size), .sq_data(sq_data), .sq_done(sq_done), .sq_seq(sq_seq),
    .wb_done(wb_done), .wb_seq(wb_seq), .blk_clear(blk_clear),
    .res_valid(res_valid), .res_ready(res_ready), .res_kind(res_kind), .res_data(res_data),
    .res_lq_idx(res_lq_idx), .res_sq_idx(res_sq_idx),
    .stall_active(stall_active), .stall_store_seq(stall_store_seq),
    .stall_load_idx(stall_load_idx), .stall_load_seq(stall_load_seq),
    .blk_active(blk_active), .blk_seq(blk_seq)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string ptag = "";

  // reference state
  bit m_rv = 0; logic [4:0] m_kind = 0; logic [63:0] m_data = 0; int m_lq = 0, m_sq = 0;
  string m_tag = "R9";
  bit m_sa = 0; int m_sss = 0, m_sli = 0, m_sls = 0;
  bit m_ba = 0; int m_bs = 0;

  task automatic chk(input string t, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("R11", "res_valid", 64'(res_valid), 64'(m_rv));
    if (m_rv) begin
      chk(m_tag, "res_kind", 64'(res_kind), 64'(m_kind));
      chk(m_tag, "res_data", res_data, m_data);
      chk(m_tag, "res_lq_idx", 64'(res_lq_idx), 64'(m_lq));
      if (m_kind[0] || m_kind[1]) chk(m_tag, "res_sq_idx", 64'(res_sq_idx), 64'(m_sq));
      chk("R12", "onehot", 64'($countones(res_kind)), 64'd1);
    end
    chk("R6", "stall_active", 64'(stall_active), 64'(m_sa));
    if (m_sa) begin
      chk("R6", "stall_store_seq", 64'(stall_store_seq), 64'(m_sss));
      chk("R6", "stall_load_idx", 64'(stall_load_idx), 64'(m_sli));
      chk("R6", "stall_load_seq", 64'(stall_load_seq), 64'(m_sls));
    end
    chk("R10", "blk_active", 64'(blk_active), 64'(m_ba));
    if (m_ba) chk("R10", "blk_seq", 64'(blk_seq), 64'(m_bs));
  endtask

  task automatic model_update();
    bit acc, unc, found, full;
    int idx, hit, la, le, sa, se, ls, off;
    logic [63:0] d;
    logic [4:0] k;
    bit sa_pend, ba_pend;
    acc = req_valid && (!m_rv || res_ready);
    unc = req_uncached && !((req_lq_idx == lq_head) && req_at_commit);
    found = 0; full = 0; hit = 0; d = 0;
    la = int'(req_addr); ls = int'(req_size); le = la + ls;
    idx = int'(req_sq_idx);
    while (!unc && !found && idx != int'(sq_wb_idx)) begin
      idx = (idx + D - 1) % D;
      if (s_size[idx] != 0) begin
        sa = s_addr[idx]; se = sa + s_size[idx];
        if (la >= sa && le <= se) begin
          found = 1; full = 1; hit = idx;
        end else if (la < se && le > sa && s_done[idx] == 0) begin
          found = 1; hit = idx;
        end
      end
    end
    if (unc)              begin k = 5'b00100; m_tag = "R8"; end
    else if (found&&full) begin k = 5'b00001; m_tag = "R4"; end
    else if (found)       begin k = 5'b00010; m_tag = "R5"; end
    else if (cache_blocked) begin k = 5'b10000; m_tag = "R9"; end
    else                  begin k = 5'b01000; m_tag = "R9"; end
    if (ptag != "" && acc) m_tag = ptag;
    if (k == 5'b00001) begin
      off = la % s_size[hit];
      d = s_data[hit] >> (off * 8);
      if (ls < 8) d = d & ((64'd1 << (ls * 8)) - 64'd1);
    end
    // trackers: release first, then record
    sa_pend = m_sa && !(wb_done && int'(wb_seq) == m_sss);
    ba_pend = m_ba && !blk_clear;
    if (acc && k == 5'b00010 && (!sa_pend || int'(req_seq) < m_sls)) begin
      m_sa = 1; m_sss = int'(s_seq[hit]); m_sli = int'(req_lq_idx); m_sls = int'(req_seq);
    end else m_sa = sa_pend;
    if (acc && k == 5'b10000 && (!ba_pend || int'(req_seq) < m_bs)) begin
      m_ba = 1; m_bs = int'(req_seq);
    end else m_ba = ba_pend;
    if (acc) begin
      m_rv = 1; m_kind = k; m_data = d; m_lq = int'(req_lq_idx); m_sq = hit;
    end else if (res_ready) m_rv = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    #1;
    chk("R11", "req_ready", 64'(req_ready), 64'(!m_rv || res_ready));
    model_update();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_uncached = 0; req_at_commit = 0; cache_blocked = 0;
    wb_done = 0; wb_seq = 0; blk_clear = 0; res_ready = 1; lq_head = 0;
    req_addr = 0; req_size = 1; req_sq_idx = 0; req_lq_idx = 0; req_seq = 0; sq_wb_idx = 0;
  endtask

  task automatic clear_sq();
    for (int i = 0; i < D; i++) begin
      s_addr[i] = 0; s_size[i] = 0; s_done[i] = 0;
      s_data[i] = 64'h0; s_seq[i] = SW'(10 + i * 10);
    end
  endtask

  task automatic send(input int a, input int sz, input int sqi, input int lqi, input int sq);
    req_addr = AW'(a); req_size = SZW'(sz); req_sq_idx = SQW'(sqi);
    req_lq_idx = LQW'(lqi); req_seq = SW'(sq); req_valid = 1;
    tick();
    req_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    clear_sq();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R11", "reset res_valid", 64'(res_valid), 64'd0);
    chk("R11", "reset req_ready", 64'(req_ready), 64'd1);
    chk("R6", "reset stall_active", 64'(stall_active), 64'd0);
    chk("R10", "reset blk_active", 64'(blk_active), 64'd0);
    @(posedge clk); #1;

    // R4: full cover, offset 2 inside an 8-byte store
    ptag = "R4";
    sq_wb_idx = 2;
    s_addr[5] = 'h10; s_size[5] = 8; s_data[5] = 64'h8877665544332211;
    send('h12, 2, 6, 1, 50);
    chk("R4", "fwd kind", 64'(res_kind), 64'h1);
    chk("R4", "fwd data", res_data, 64'h4433);
    chk("R4", "fwd slot", 64'(res_sq_idx), 64'd5);

    // R1: empty window, slot outside window, wrapped window
    ptag = "R1";
    sq_wb_idx = 6;
    send('h12, 2, 6, 1, 51);
    chk("R1", "empty window kind", 64'(res_kind), 64'h8);
    sq_wb_idx = 2;
    s_size[5] = 0; s_addr[1] = 'h10; s_size[1] = 8; s_data[1] = 64'h8877665544332211;
    send('h10, 4, 6, 1, 52);
    chk("R1", "outside window kind", 64'(res_kind), 64'h8);
    sq_wb_idx = 6;
    send('h10, 4, 2, 1, 53);
    chk("R1", "wrapped window kind", 64'(res_kind), 64'h1);
    chk("R1", "wrapped window slot", 64'(res_sq_idx), 64'd1);

    // R2: youngest covering store wins
    ptag = "R2";
    clear_sq(); sq_wb_idx = 0;
    s_addr[4] = 'h20; s_size[4] = 4; s_data[4] = 64'h00000000DEADBEEF;
    s_addr[3] = 'h20; s_size[3] = 8; s_data[3] = 64'h1111111111111111;
    send('h20, 4, 6, 2, 60);
    chk("R2", "youngest slot", 64'(res_sq_idx), 64'd4);
    chk("R2", "youngest data", res_data, 64'hDEADBEEF);

    // R3: zero-size slot ahead of a covering store
    ptag = "R3";
    s_addr[5] = 'h20; s_size[5] = 0; s_data[5] = 64'hFFFFFFFFFFFFFFFF;
    send('h20, 4, 6, 2, 61);
    chk("R3", "zero size skipped", 64'(res_sq_idx), 64'd4);

    // R5: partial overlap incomplete, then completed and passed over
    ptag = "R5";
    clear_sq(); sq_wb_idx = 0;
    s_addr[3] = 'h40; s_size[3] = 2; s_seq[3] = 33;
    send('h40, 4, 5, 2, 90);
    chk("R5", "partial stall kind", 64'(res_kind), 64'h2);
    chk("R6", "stall store seq", 64'(stall_store_seq), 64'd33);
    s_done[3] = 1; s_addr[1] = 'h40; s_size[1] = 8; s_data[1] = 64'h0123456789ABCDEF;
    send('h40, 4, 5, 3, 91);
    chk("R5", "done partial passed", 64'(res_kind), 64'h1);
    chk("R5", "done partial data", res_data, 64'h89ABCDEF);

    // R6: younger load keeps the record, older load replaces it
    ptag = "R6";
    s_done[3] = 0;
    send('h40, 4, 5, 4, 120);
    chk("R6", "younger keeps seq", 64'(stall_load_seq), 64'd90);
    send('h40, 4, 5, 5, 70);
    chk("R6", "older replaces seq", 64'(stall_load_seq), 64'd70);
    chk("R6", "older replaces idx", 64'(stall_load_idx), 64'd5);

    // R7: mismatched release, same-cycle release and set, plain release
    ptag = "R7";
    wb_done = 1; wb_seq = 99; tick(); wb_done = 0;
    chk("R7", "mismatch keeps", 64'(stall_active), 64'd1);
    wb_done = 1; wb_seq = 33;
    send('h40, 4, 5, 6, 200);
    wb_done = 0;
    chk("R7", "release then set seq", 64'(stall_load_seq), 64'd200);
    chk("R7", "release then set active", 64'(stall_active), 64'd1);
    wb_done = 1; wb_seq = 33; tick(); wb_done = 0;
    chk("R7", "released", 64'(stall_active), 64'd0);

    // R8: uncacheable gating
    ptag = "R8";
    clear_sq(); req_uncached = 1; lq_head = 0; req_at_commit = 1; cache_blocked = 1;
    send('h80, 8, 4, 3, 15);
    chk("R8", "not head kind", 64'(res_kind), 64'h4);
    chk("R8", "no blk record", 64'(blk_active), 64'd0);
    req_at_commit = 0;
    send('h80, 8, 4, 0, 16);
    chk("R8", "not commit kind", 64'(res_kind), 64'h4);
    req_at_commit = 1; cache_blocked = 0;
    send('h80, 8, 4, 0, 17);
    chk("R8", "head and commit kind", 64'(res_kind), 64'h8);
    req_uncached = 0;

    // R9 / R10: cache blocked and the blocked record
    ptag = "R10";
    cache_blocked = 1;
    send('h80, 8, 4, 1, 80);
    chk("R9", "blocked kind", 64'(res_kind), 64'h10);
    chk("R10", "blk seq", 64'(blk_seq), 64'd80);
    send('h80, 8, 4, 1, 90);
    chk("R10", "younger keeps", 64'(blk_seq), 64'd80);
    send('h80, 8, 4, 1, 40);
    chk("R10", "older replaces", 64'(blk_seq), 64'd40);
    blk_clear = 1;
    send('h80, 8, 4, 1, 100);
    chk("R10", "clear then set", 64'(blk_seq), 64'd100);
    cache_blocked = 0;
    tick(); blk_clear = 0;
    chk("R10", "cleared", 64'(blk_active), 64'd0);

    // R11: back-pressure holds the result and refuses requests
    ptag = "R11";
    res_ready = 0;
    send('h80, 8, 4, 2, 5);
    send('h90, 8, 4, 3, 6);
    chk("R11", "held valid", 64'(res_valid), 64'd1);
    chk("R11", "held lq idx", 64'(res_lq_idx), 64'd2);
    chk("R11", "ready low", 64'(req_ready), 64'd0);
    res_ready = 1;
    tick();
    ptag = "";

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      if (c % 8 == 0) begin
        for (int i = 0; i < D; i++) begin
          int kk, sz;
          kk = $urandom_range(0, 4);
          sz = (kk == 0) ? 0 : (1 << (kk - 1));
          s_size[i] = sz;
          s_addr[i] = (sz == 0) ? $urandom_range(0, 31) : ($urandom_range(0, 31) & ~(sz - 1));
          s_data[i] = {$urandom, $urandom};
          s_done[i] = ($urandom_range(0, 3) == 0) ? 1 : 0;
          s_seq[i]  = SW'($urandom_range(0, 255));
        end
        sq_wb_idx = SQW'($urandom_range(0, D - 1));
      end
      begin
        int lsz;
        lsz = 1 << $urandom_range(0, 3);
        req_size = SZW'(lsz);
        req_addr = AW'($urandom_range(0, 31) & ~(lsz - 1));
      end
      req_valid     = ($urandom_range(0, 9) < 7);
      req_sq_idx    = SQW'($urandom_range(0, D - 1));
      req_lq_idx    = LQW'($urandom_range(0, 7));
      req_seq       = SW'($urandom_range(0, 255));
      req_uncached  = ($urandom_range(0, 6) == 0);
      req_at_commit = $urandom_range(0, 1);
      lq_head       = LQW'($urandom_range(0, 1));
      cache_blocked = ($urandom_range(0, 9) < 3);
      res_ready     = ($urandom_range(0, 3) != 0);
      wb_done       = ($urandom_range(0, 4) == 0);
      wb_seq        = ($urandom_range(0, 1) == 0) ? SW'(m_sss) : SW'($urandom_range(0, 255));
      blk_clear     = ($urandom_range(0, 19) == 0);
      tick();
    end
    idle_inputs();
    tick();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule